// File: doc/BRIEF.md
# Fully Associative Translation Cache

This block keeps a small set of recently used page-to-frame mappings and sits between an address requester and a page-table walker. A request carries a virtual page number and an in-page offset. The block searches every stored mapping at once. When the page is present, it returns the stored frame number joined to the offset, and no table walk is needed.

The block starts the walker in the same cycle as the fast search, so a miss loses no time before the walk begins. A hit sends a cancel pulse to the walker. On a miss, the block waits for the walker's frame number, returns the translation and installs the mapping. Free entries are used before any valid entry is replaced. Once every entry is valid, victims are taken in round-robin order.

A flush input drops every mapping in one edge, for use on a context switch. Two counters report the number of hits and misses.

Top module: `xlat_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and walk_start are 0, both counters are 0, and every entry is invalid.
- R2: A request is accepted at a rising edge while req_valid and req_ready are both 1. In the next cycle, walk_start is 1 for exactly one cycle and walk_vpn equals the accepted page number.
- R3: If the page is cached, rsp_valid, rsp_hit and walk_cancel are 1 in the cycle after the walk_start cycle. rsp_paddr is {stored frame, offset}, with the offset in the low OFF_W bits.
- R4: On a miss, rsp_valid stays 0 until the walker answers. The walker answers with walk_resp_valid high at an edge while the block waits. In the next cycle, rsp_valid is 1, rsp_hit is 0, walk_cancel is 0 and rsp_paddr is {walk_resp_pfn, offset}.
- R5: A mapping installed by a miss makes later requests to the same page hit with that frame, and no page is ever held in two entries.
- R6: No valid entry is replaced while an invalid one exists; invalid entries are filled lowest index first.
- R7: When all entries are valid, the entry at a victim pointer is replaced. The pointer starts at 0, steps by one after each such replacement and wraps after the last entry.
- R8: A flush sampled at an edge invalidates every entry and returns the victim pointer to 0. A fill at the same edge still answers the request but is not installed.
- R9: hit_count increments once per hit response and miss_count once per detected miss. The miss count is visible in the cycle after the walk_start cycle.
- R10: req_ready is 0 from the walk_start cycle until the response cycle, and requests are not accepted meanwhile.
- R11: A walker answer while no miss is outstanding is ignored and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all mappings |
| req_valid | input | 1 | Translation request |
| req_vpn | input | VPN_W | Requested page number |
| req_off | input | OFF_W | In-page offset |
| req_ready | output | 1 | Block idle, request can be taken |
| walk_start | output | 1 | Start a table walk (one-cycle pulse) |
| walk_vpn | output | VPN_W | Page number for the walker |
| walk_cancel | output | 1 | Abort the walk just started (hit) |
| walk_resp_valid | input | 1 | Walker returns a frame |
| walk_resp_pfn | input | PFN_W | Frame number from the walker |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_hit | output | 1 | Result came from a cached entry |
| rsp_paddr | output | PFN_W+OFF_W | Physical address |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
The assertions check four things on every cycle: the one-cycle walk pulse, that cancel comes only with a hit response, that at most one entry matches, and that a free entry is chosen while one exists. They also check that a flush leaves no valid entry, that a fill produces a miss response, and that the hit counter moves by one per hit. Only the bench's scenarios can show that the right entry is chosen for eviction in round-robin order after the buffer fills. The same holds for a fill coinciding with a flush being dropped, a stray walker answer being ignored, and the returned addresses matching a page table the bench computes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WAIT = 2'd2
  } xlat_state_e;

  function automatic int unsigned idx_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/xlat_tag_array.sv
module xlat_tag_array #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = xlat_pkg::idx_width(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [VPN_W-1:0]   wr_tag,
  input  logic [VPN_W-1:0]   look_tag,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [ENTRIES-1:0] match_vec
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic             v_q;
    logic [VPN_W-1:0] t_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        v_q <= 1'b0;
      end else if (flush) begin
        v_q <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(e))) begin
        v_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(e))) t_q <= wr_tag;
    end

    assign valid_vec[e] = v_q;
    assign match_vec[e] = v_q && (t_q == look_tag);
  end

  // R5: a page is never held in two entries
  assert_single_match_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match_vec));
endmodule

// File: rtl/xlat_frame_store.sv
module xlat_frame_store #(
  parameter int ENTRIES = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = xlat_pkg::idx_width(ENTRIES)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [PFN_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PFN_W-1:0] rd_data
);
  logic [PFN_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = xlat_pkg::idx_width(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               evict,
  output logic [IDX_W-1:0]   victim_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_found;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign victim_idx = free_found ? free_idx : ptr_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr_q <= '0;
    end else if (evict && !free_found) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  // R6: a free slot is always preferred over a live one
  assert_fill_invalid_first_R6: assert property (@(posedge clk) disable iff (rst)
    !(&valid_vec) |-> !valid_vec[victim_idx]);

  // R7: pointer stays inside the entry range
  assert_ptr_range_R7: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST);
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  parameter int CNT_W   = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   req_valid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  output logic                   req_ready,
  output logic                   walk_start,
  output logic [VPN_W-1:0]       walk_vpn,
  output logic                   walk_cancel,
  input  logic                   walk_resp_valid,
  input  logic [PFN_W-1:0]       walk_resp_pfn,
  output logic                   rsp_valid,
  output logic                   rsp_hit,
  output logic [PFN_W+OFF_W-1:0] rsp_paddr,
  output logic [CNT_W-1:0]       hit_count,
  output logic [CNT_W-1:0]       miss_count
);
  import xlat_pkg::*;

  localparam int IDX_W = idx_width(ENTRIES);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  xlat_state_e        state_q;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] match_vec;
  logic [IDX_W-1:0]   hit_idx;
  logic [IDX_W-1:0]   victim_idx;
  logic [PFN_W-1:0]   hit_pfn;
  logic               hit;
  logic               install;

  assign hit       = |match_vec;
  assign install   = (state_q == ST_WAIT) && walk_resp_valid && !flush;
  assign req_ready = (state_q == ST_IDLE);
  assign walk_vpn  = vpn_q;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  xlat_tag_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_tags (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_en(install), .wr_idx(victim_idx), .wr_tag(vpn_q),
    .look_tag(vpn_q), .valid_vec(valid_vec), .match_vec(match_vec)
  );

  xlat_frame_store #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) u_frames (
    .clk(clk), .wr_en(install), .wr_idx(victim_idx), .wr_data(walk_resp_pfn),
    .rd_idx(hit_idx), .rd_data(hit_pfn)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst(rst), .flush(flush), .valid_vec(valid_vec),
    .evict(install), .victim_idx(victim_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      vpn_q       <= '0;
      off_q       <= '0;
      walk_start  <= 1'b0;
      walk_cancel <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_paddr   <= '0;
      hit_count   <= '0;
      miss_count  <= '0;
    end else begin
      walk_start  <= 1'b0;
      walk_cancel <= 1'b0;
      rsp_valid   <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q      <= req_vpn;
            off_q      <= req_off;
            walk_start <= 1'b1;
            state_q    <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            rsp_valid   <= 1'b1;
            rsp_hit     <= 1'b1;
            rsp_paddr   <= {hit_pfn, off_q};
            walk_cancel <= 1'b1;
            hit_count   <= hit_count + CNT_ONE;
            state_q     <= ST_IDLE;
          end else begin
            miss_count  <= miss_count + CNT_ONE;
            state_q     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (walk_resp_valid) begin
            rsp_valid <= 1'b1;
            rsp_hit   <= 1'b0;
            rsp_paddr <= {walk_resp_pfn, off_q};
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: the walk start is a single-cycle pulse
  assert_walk_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    walk_start |=> !walk_start);

  // R10: the block is busy while a walk is being started
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    walk_start |-> !req_ready);

  // R3: cancel only accompanies a hit response
  assert_cancel_with_hit_R3: assert property (@(posedge clk) disable iff (rst)
    walk_cancel |-> (rsp_valid && rsp_hit));

  // R4: a walker answer while waiting produces a miss response
  assert_fill_response_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && walk_resp_valid) |=> (rsp_valid && !rsp_hit));

  // R8: a flush leaves no valid entry behind
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (valid_vec == '0));

  // R9: each hit response advances the hit counter by one
  assert_hit_count_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (hit_count == $past(hit_count) + CNT_ONE));
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_vpn = '0;
  logic [11:0] req_off = '0;
  logic        req_ready;
  logic        walk_start;
  logic [19:0] walk_vpn;
  logic        walk_cancel;
  logic        walk_resp_valid = 1'b0;
  logic [19:0] walk_resp_pfn = '0;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [31:0] rsp_paddr;
  logic [15:0] hit_count;
  logic [15:0] miss_count;

  xlat_cache u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off), .req_ready(req_ready),
    .walk_start(walk_start), .walk_vpn(walk_vpn), .walk_cancel(walk_cancel),
    .walk_resp_valid(walk_resp_valid), .walk_resp_pfn(walk_resp_pfn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int salt = 0;
  int exp_hits = 0;
  int exp_misses = 0;
  logic        last_hit;
  logic [19:0] m_tag [N];
  logic [19:0] m_pfn [N];
  bit          m_val [N];
  int          m_ptr = 0;

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic logic [19:0] table_pfn(logic [19:0] v);
    logic [31:0] t;
    t = (32'(v) * 32'd40503) ^ 32'(salt * 977);
    return t[19:0];
  endfunction

  function automatic int model_find(logic [19:0] v);
    for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == v) return i;
    return -1;
  endfunction

  task automatic model_install(logic [19:0] v, logic [19:0] p);
    int slot;
    slot = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_val[i]) slot = i;
    if (slot < 0) begin
      slot = m_ptr;
      m_ptr = (m_ptr + 1) % N;
    end
    m_val[slot] = 1'b1;
    m_tag[slot] = v;
    m_pfn[slot] = p;
  endtask

  task automatic model_flush();
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    m_ptr = 0;
    salt++;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_flush();
  endtask

  task automatic do_xlat(logic [19:0] v, logic [11:0] off, int lat, bit flush_fill);
    int idx;
    logic [19:0] p;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vpn = v; req_off = off;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 walk_start", 64'(walk_start), 64'd1);
    check("R2 walk_vpn", 64'(walk_vpn), 64'(v));
    check("R10 req_ready busy", 64'(req_ready), 64'd0);
    idx = model_find(v);
    @(negedge clk);
    if (idx >= 0) begin
      exp_hits++;
      check("R3 rsp_valid", 64'(rsp_valid), 64'd1);
      check("R3 rsp_hit", 64'(rsp_hit), 64'd1);
      check("R3 rsp_paddr", 64'(rsp_paddr), 64'({m_pfn[idx], off}));
      check("R3 walk_cancel", 64'(walk_cancel), 64'd1);
      check("R9 hit_count", 64'(hit_count), 64'(exp_hits));
      last_hit = rsp_hit;
    end else begin
      exp_misses++;
      check("R4 no early rsp", 64'(rsp_valid), 64'd0);
      check("R3 no cancel on miss", 64'(walk_cancel), 64'd0);
      check("R9 miss_count", 64'(miss_count), 64'(exp_misses));
      for (int k = 0; k < lat; k++) begin
        @(negedge clk);
        check("R4 waits for walker", 64'(rsp_valid), 64'd0);
      end
      p = table_pfn(v);
      walk_resp_valid = 1'b1; walk_resp_pfn = p; flush = flush_fill;
      @(negedge clk);
      walk_resp_valid = 1'b0; flush = 1'b0;
      check("R4 rsp_valid", 64'(rsp_valid), 64'd1);
      check("R4 rsp_hit", 64'(rsp_hit), 64'd0);
      check("R4 rsp_paddr", 64'(rsp_paddr), 64'({p, off}));
      last_hit = rsp_hit;
      if (flush_fill) model_flush();
      else model_install(v, p);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < N; i++) m_val[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 walk_start", 64'(walk_start), 64'd0);
    check("R1 hit_count", 64'(hit_count), 64'd0);
    check("R1 miss_count", 64'(miss_count), 64'd0);

    // R1 / R4 / R5: first access misses, second hits
    do_xlat(20'd5, 12'h123, 2, 1'b0);
    check("R1 empty after reset", 64'(last_hit), 64'd0);
    do_xlat(20'd5, 12'hABC, 0, 1'b0);
    check("R5 installed page hits", 64'(last_hit), 64'd1);

    // R6: fill the remaining free entries, nothing is evicted
    for (int i = 0; i < N - 1; i++) do_xlat(20'(100 + i), 12'(i), 1, 1'b0);
    for (int i = 0; i < N - 1; i++) begin
      do_xlat(20'(100 + i), 12'(i * 3), 0, 1'b0);
      check("R6 no eviction while free", 64'(last_hit), 64'd1);
    end
    do_xlat(20'd5, 12'h001, 0, 1'b0);
    check("R6 first page kept", 64'(last_hit), 64'd1);

    // R7: round-robin eviction from entry 0 onward
    do_xlat(20'd200, 12'h010, 1, 1'b0);
    do_xlat(20'd5, 12'h020, 0, 1'b0);
    check("R7 entry 0 evicted first", 64'(last_hit), 64'd0);
    do_xlat(20'd101, 12'h030, 0, 1'b0);
    check("R7 entry 2 still live", 64'(last_hit), 64'd1);
    do_xlat(20'd100, 12'h040, 0, 1'b0);
    check("R7 entry 1 evicted second", 64'(last_hit), 64'd0);

    // R11: stray walker answer while idle
    @(negedge clk);
    walk_resp_valid = 1'b1; walk_resp_pfn = 20'hFFFFF;
    @(negedge clk);
    walk_resp_valid = 1'b0;
    check("R11 stray answer ignored", 64'(rsp_valid), 64'd0);
    do_xlat(20'd321, 12'h055, 1, 1'b0);
    check("R11 page not installed", 64'(last_hit), 64'd0);

    // R8: flush drops cached pages; mapping changes after it
    do_flush();
    do_xlat(20'd101, 12'h066, 1, 1'b0);
    check("R8 flushed page misses", 64'(last_hit), 64'd0);
    do_xlat(20'd300, 12'h077, 2, 1'b1);
    do_xlat(20'd300, 12'h088, 0, 1'b0);
    check("R8 fill with flush not kept", 64'(last_hit), 64'd0);
    do_xlat(20'd300, 12'h099, 0, 1'b0);
    check("R8 later fill kept", 64'(last_hit), 64'd1);

    // random traffic over a small page pool
    for (int t = 0; t < 400; t++) begin
      if ($urandom_range(0, 39) == 0) do_flush();
      do_xlat(20'(400 + $urandom_range(0, 11)), 12'($urandom), int'($urandom_range(0, 3)),
              ($urandom_range(0, 29) == 0));
    end

    @(negedge clk);
    check("R9 final hit_count", 64'(hit_count), 64'(exp_hits));
    check("R9 final miss_count", 64'(miss_count), 64'(exp_misses));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule